// File: doc/BRIEF.md
# Self-Routing Butterfly Switch Network

This block is an N-port by N-port multistage switch. It is built from 2x2 switching elements arranged in log2(N) registered stages of N/2 elements each. A packet presented at an input carries a destination index and a payload. The input port number is its source index. On entry the network forms a routing word as the source index XOR the destination index. The routing word travels with the packet. The element at stage i reads only bit i of the word: a 0 keeps the packet on its lane (straight), and a 1 moves it to the partner lane whose index differs in bit i (cross). After the last stage the lane index equals the destination, so each source/destination pair has one fixed path and no tables are needed.

Every link between stages uses valid/ready handshaking. Each element output is a single register. When both inputs of an element want the same output in one cycle, a round-robin arbiter picks one. The other input keeps its packet and sees ready low. At the far side, each output port also reports the source index of the packet it delivers. That index is recovered from the routing word.

Top module: `bfly_net`

## Requirements
- R1: With all outputs ready and no contention, a packet accepted at an input appears at its output exactly log2(N) cycles later. Every packet passes through all stages whatever its destination.
- R2: A packet entered at input s with destination d leaves on output port d, and out_src on that port equals s.
- R3: The payload word leaves the network bit for bit as it entered.
- R4: At stage i, a packet goes straight when bit i of (source XOR destination) is 0 and crosses when it is 1. As a result, any set of N packets that share one routing word (destination = source XOR a constant) is accepted in one cycle with no stall.
- R5: When two inputs of an element ask for the same output in one cycle, exactly one is accepted. The other keeps in_ready low, and it is accepted in the next cycle if the output has room.
- R6: While an output is valid and its ready is low, the valid stays high and the data and source fields stay unchanged.
- R7: Contention is resolved round-robin. After an input wins a contended output, the other input wins the next contention for that output.
- R8: After a synchronous active-low reset, every out_valid is 0, and in_ready is 0 on inputs that present no valid packet.
- R9: Under random traffic and random output backpressure, every injected packet is delivered exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | N | Packet present at each input |
| in_ready | output | N | Input packet accepted this cycle |
| in_dst | input | N x log2(N) | Destination index per input |
| in_data | input | N x W | Payload per input |
| out_valid | output | N | Packet present at each output |
| out_ready | input | N | Sink accepts the output packet |
| out_src | output | N x log2(N) | Source index of the delivered packet |
| out_data | output | N x W | Delivered payload |

## Verification
Inputs are driven just after the falling edge, and transfers are recorded one nanosecond later, before the next rising edge. A packet recorded as accepted in bench cycle c is therefore due at its output in bench cycle c + log2(N) when nothing stalls. The latency check compares the arrival count against exactly that value. Arbitration results appear combinationally on in_ready in the same cycle the contending packets are driven. The loser must show ready one cycle later. Held outputs are compared after each rising edge for as long as the sink keeps ready low. In the random phase, latency is not checked; every delivery is instead matched against a per-packet record of destination, source and payload checksum.

// File: rtl/bfly_pkg.sv
// Shared helpers for the butterfly network.
// Assumes stage indices and lane counts stay below 32.
package bfly_pkg;

    // Direction a packet takes through one element.
    typedef enum logic {
        TURN_STRAIGHT = 1'b0,
        TURN_CROSS    = 1'b1
    } turn_e;

    // Lower lane of element e in stage stg: bit stg of the lane index forced to zero.
    function automatic int lo_lane(input int e, input int stg);
        return ((e >> stg) << (stg + 1)) | (e & ((1 << stg) - 1));
    endfunction

endpackage

// File: rtl/bfly_elem.sv
// 2x2 switching element for stage STG.
// Input s targets output s ^ route[STG]. Contention is resolved round-robin per output.
// Each output is one register. Ready upstream depends on valid, grant and room downstream.
// Assumes upstream holds valid and data stable while ready is low.
module bfly_elem
    import bfly_pkg::*;
#(
    parameter int LG  = 3,
    parameter int W   = 16,
    parameter int STG = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           in_v,
    output logic [1:0]           in_rdy,
    input  logic [1:0][LG-1:0]   in_r,
    input  logic [1:0][W-1:0]    in_d,
    output logic [1:0]           out_v,
    input  logic [1:0]           out_rdy,
    output logic [1:0][LG-1:0]   out_r,
    output logic [1:0][W-1:0]    out_d
);

    logic [1:0]      tgt;    // output wanted by each input
    logic [1:0][1:0] req;    // req[o][s]
    logic [1:0][1:0] gnt;    // gnt[o][s]
    logic [1:0]      space;  // output register can take a packet
    logic [1:0]      prio;   // preferred input per output

    // Route decision, arbitration and upstream ready.
    always_comb begin
        for (int s = 0; s < 2; s++) begin
            tgt[s] = logic'(s[0]) ^ (turn_e'(in_r[s][STG]) == TURN_CROSS);
        end
        for (int o = 0; o < 2; o++) begin
            space[o] = !out_v[o] || out_rdy[o];
            for (int s = 0; s < 2; s++) begin
                req[o][s] = in_v[s] && (tgt[s] == logic'(o[0]));
            end
            gnt[o][0] = req[o][0] && (!req[o][1] || prio[o] == 1'b0);
            gnt[o][1] = req[o][1] && (!req[o][0] || prio[o] == 1'b1);
        end
        for (int s = 0; s < 2; s++) begin
            in_rdy[s] = gnt[tgt[s]][s] && space[tgt[s]];
        end
    end

    // Output registers and round-robin pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_v <= '0;
            prio  <= '0;
            out_r <= '0;
            out_d <= '0;
        end else begin
            for (int o = 0; o < 2; o++) begin
                if (space[o]) begin
                    out_v[o] <= |gnt[o];
                    if (gnt[o][1]) begin
                        out_r[o] <= in_r[1];
                        out_d[o] <= in_d[1];
                    end else if (gnt[o][0]) begin
                        out_r[o] <= in_r[0];
                        out_d[o] <= in_d[0];
                    end
                    if (&req[o]) begin
                        prio[o] <= !gnt[o][1];
                    end
                end
            end
        end
    end

    // Checks on routing, waiting inputs, held outputs and fairness.
    for (genvar s = 0; s < 2; s++) begin : g_in_chk
        localparam int OTHER = 1 - s;
        p_route_straight_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (in_v[s] && in_rdy[s] && !in_r[s][STG]) |=> (out_v[s] && out_d[s] == $past(in_d[s])));
        p_route_cross_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (in_v[s] && in_rdy[s] && in_r[s][STG]) |=> (out_v[OTHER] && out_d[OTHER] == $past(in_d[s])));
        p_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_v[s] && !in_rdy[s]) |=> (in_v[s] && $stable(in_d[s]) && $stable(in_r[s])));
    end

    for (genvar o = 0; o < 2; o++) begin : g_out_chk
        p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (out_v[o] && !out_rdy[o]) |=> (out_v[o] && $stable(out_d[o]) && $stable(out_r[o])));
        p_fair_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (&req[o] && space[o] && gnt[o][0]) |=> !(&req[o] && space[o] && gnt[o][0]));
    end

endmodule

// File: rtl/bfly_stage.sv
// One stage of N/2 elements. Element e joins the lanes that differ only in bit STG.
// Lane positions are kept between stages; the partner pairing alone forms the butterfly.
module bfly_stage
    import bfly_pkg::*;
#(
    parameter int N   = 8,
    parameter int W   = 16,
    parameter int STG = 0,
    localparam int LG = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         in_v,
    output logic [N-1:0]         in_rdy,
    input  logic [N-1:0][LG-1:0] in_r,
    input  logic [N-1:0][W-1:0]  in_d,
    output logic [N-1:0]         out_v,
    input  logic [N-1:0]         out_rdy,
    output logic [N-1:0][LG-1:0] out_r,
    output logic [N-1:0][W-1:0]  out_d
);

    localparam int HALF = N / 2;

    for (genvar e = 0; e < HALF; e++) begin : g_el
        localparam int LA = lo_lane(e, STG);
        localparam int LB = LA + (1 << STG);

        logic [1:0]          e_rdy;
        logic [1:0]          e_ov;
        logic [1:0][LG-1:0]  e_or;
        logic [1:0][W-1:0]   e_od;

        bfly_elem #(.LG(LG), .W(W), .STG(STG)) u_el (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_v    ({in_v[LB], in_v[LA]}),
            .in_rdy  (e_rdy),
            .in_r    ({in_r[LB], in_r[LA]}),
            .in_d    ({in_d[LB], in_d[LA]}),
            .out_v   (e_ov),
            .out_rdy ({out_rdy[LB], out_rdy[LA]}),
            .out_r   (e_or),
            .out_d   (e_od)
        );

        assign in_rdy[LA] = e_rdy[0];
        assign in_rdy[LB] = e_rdy[1];
        assign out_v[LA]  = e_ov[0];
        assign out_v[LB]  = e_ov[1];
        assign out_r[LA]  = e_or[0];
        assign out_r[LB]  = e_or[1];
        assign out_d[LA]  = e_od[0];
        assign out_d[LB]  = e_od[1];
    end

endmodule

// File: rtl/bfly_net.sv
// N x N self-routing butterfly network of log2(N) registered stages.
// Forms the routing word (port XOR destination) on entry and recovers the source at the exit.
// Assumes N is a power of two from 4 to 32.
module bfly_net #(
    parameter int N = 8,
    parameter int W = 16,
    localparam int LG = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         in_valid,
    output logic [N-1:0]         in_ready,
    input  logic [N-1:0][LG-1:0] in_dst,
    input  logic [N-1:0][W-1:0]  in_data,
    output logic [N-1:0]         out_valid,
    input  logic [N-1:0]         out_ready,
    output logic [N-1:0][LG-1:0] out_src,
    output logic [N-1:0][W-1:0]  out_data
);

    logic [LG:0][N-1:0]         lv;
    logic [LG:0][N-1:0]         lrdy;
    logic [LG:0][N-1:0][LG-1:0] lr;
    logic [LG:0][N-1:0][W-1:0]  ld;

    // Entry side: routing word per input lane.
    always_comb begin
        for (int p = 0; p < N; p++) begin
            lr[0][p] = LG'(p) ^ in_dst[p];
        end
    end

    assign lv[0]     = in_valid;
    assign ld[0]     = in_data;
    assign in_ready  = lrdy[0];
    assign lrdy[LG]  = out_ready;
    assign out_valid = lv[LG];
    assign out_data  = ld[LG];

    // Exit side: source index from lane and routing word.
    always_comb begin
        for (int p = 0; p < N; p++) begin
            out_src[p] = LG'(p) ^ lr[LG][p];
        end
    end

    for (genvar k = 0; k < LG; k++) begin : g_stage
        bfly_stage #(.N(N), .W(W), .STG(k)) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_v    (lv[k]),
            .in_rdy  (lrdy[k]),
            .in_r    (lr[k]),
            .in_d    (ld[k]),
            .out_v   (lv[k+1]),
            .out_rdy (lrdy[k+1]),
            .out_r   (lr[k+1]),
            .out_d   (ld[k+1])
        );
    end

endmodule

// File: tb/sim_bfly_net.sv
`timescale 1ns/1ps
module sim_bfly_net;
    localparam int N  = 8;
    localparam int W  = 16;
    localparam int LG = 3;
    localparam int MAXP = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]         in_valid = '0;
    logic [N-1:0]         in_ready;
    logic [N-1:0][LG-1:0] in_dst = '0;
    logic [N-1:0][W-1:0]  in_data = '0;
    logic [N-1:0]         out_valid;
    logic [N-1:0]         out_ready = '1;
    logic [N-1:0][LG-1:0] out_src;
    logic [N-1:0][W-1:0]  out_data;

    always #10 clk = ~clk;

    bfly_net #(.N(N), .W(W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_dst(in_dst), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_src(out_src), .out_data(out_data)
    );

    int checks = 0, errors = 0, cyc = 0, npk = 0;
    bit finished = 0;
    int exp_dst[MAXP], exp_src[MAXP], acc_c[MAXP];
    bit got[MAXP];
    bit [N-1:0] took = '0;
    bit lat_on = 0;

    // Payload: checksum in the top 6 bits, packet id in the low 10 bits.
    function automatic logic [W-1:0] mk(input int id);
        return {6'((id * 7 + 3) & 63), 10'(id)};
    endfunction

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic put(input int p, input int d);
        exp_dst[npk] = d;
        exp_src[npk] = p;
        got[npk]     = 0;
        in_valid[p]  = 1'b1;
        in_dst[p]    = LG'(d);
        in_data[p]   = mk(npk);
        npk++;
    endtask

    // Record transfers that happen at the coming rising edge.
    task automatic observe();
        for (int p = 0; p < N; p++) begin
            if (in_valid[p] && in_ready[p]) begin
                acc_c[int'(in_data[p][9:0])] = cyc;
                took[p] = 1'b1;
            end
        end
        for (int p = 0; p < N; p++) begin
            if (out_valid[p] && out_ready[p]) begin
                int id;
                id = int'(out_data[p][9:0]);
                if (id >= npk) begin
                    chk(0, "R9", "unknown packet id", id, npk);
                end else begin
                    chk(!got[id], "R9", "second delivery of id", id, -1);
                    chk(out_data[p] == mk(id), "R3", "payload", int'(out_data[p]), int'(mk(id)));
                    chk(p == exp_dst[id], "R2", "output port", p, exp_dst[id]);
                    chk(int'(out_src[p]) == exp_src[id], "R2", "source index", int'(out_src[p]), exp_src[id]);
                    if (lat_on) chk(cyc - acc_c[id] == LG, "R1", "latency", cyc - acc_c[id], LG);
                    got[id] = 1'b1;
                end
            end
        end
    endtask

    task automatic tick();
        #1;
        observe();
        @(negedge clk);
        for (int p = 0; p < N; p++) if (took[p]) in_valid[p] = 1'b0;
        took = '0;
        cyc++;
    endtask

    initial begin
        #(20 * 150000);
        chk(0, "WDOG", "watchdog expired at cycle", cyc, 0);
        summary();
    end

    initial begin
        int w0, w;
        int id;
        logic [W-1:0] held;
        int sent;

        // R8: reset state
        repeat (3) @(negedge clk);
        chk(out_valid == '0, "R8", "out_valid after reset", int'(out_valid), 0);
        #1;
        chk(in_ready == '0, "R8", "in_ready with no valid", int'(in_ready), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3: every single source/destination pair
        lat_on = 1;
        for (int s = 0; s < N; s++) begin
            for (int d = 0; d < N; d++) begin
                id = npk;
                put(s, d);
                repeat (LG + 2) tick();
                chk(got[id], "R2", "single packet delivered", int'(got[id]), 1);
            end
        end

        // R4: shared routing word, all inputs at once, no stall
        for (int c = 0; c < N; c++) begin
            for (int p = 0; p < N; p++) put(p, p ^ c);
            #1;
            chk(in_ready == '1, "R4", "all inputs accepted for xor constant", int'(in_ready), (1 << N) - 1);
            repeat (LG + 2) tick();
        end
        lat_on = 0;

        // R5 R7: inputs 0 and 1 both to destination 0 collide in stage 0
        w0 = 0;
        for (int t = 0; t < 2; t++) begin
            put(0, 0);
            put(1, 0);
            #1;
            chk($countones(in_ready[1:0]) == 1, "R5", "single winner", int'(in_ready[1:0]), 1);
            w = in_ready[1] ? 1 : 0;
            if (t == 1) chk(w != w0, "R7", "winner alternates", w, 1 - w0);
            w0 = w;
            tick();
            #1;
            chk(in_ready[1 - w] == 1'b1, "R5", "loser accepted next cycle", int'(in_ready[1 - w]), 1);
            repeat (LG + 3) tick();
            chk(got[npk - 1] && got[npk - 2], "R5", "both contenders delivered", int'(got[npk - 1] && got[npk - 2]), 1);
        end

        // R6: output held under backpressure
        id = npk;
        put(0, 3);
        out_ready[3] = 1'b0;
        for (int k = 0; k < 10 && !out_valid[3]; k++) tick();
        chk(out_valid[3], "R6", "packet reached blocked output", int'(out_valid[3]), 1);
        held = out_data[3];
        for (int k = 0; k < 4; k++) begin
            tick();
            chk(out_valid[3] && out_data[3] == held, "R6", "held output data", int'(out_data[3]), int'(held));
        end
        out_ready[3] = 1'b1;
        repeat (LG + 2) tick();
        chk(got[id], "R6", "released packet delivered", int'(got[id]), 1);

        // R9: random traffic with random backpressure
        sent = 0;
        for (int k = 0; k < 20000; k++) begin
            for (int p = 0; p < N; p++) begin
                if (!in_valid[p] && sent < 400 && ($urandom % 2) == 1) begin
                    put(p, int'($urandom % N));
                    sent++;
                end
            end
            out_ready = N'($urandom | $urandom);
            tick();
            if (sent == 400 && in_valid == '0 && out_valid == '0) break;
        end
        out_ready = '1;
        repeat (LG + 2) tick();
        for (int i = 0; i < npk; i++) begin
            if (!got[i]) chk(0, "R9", "packet never delivered, id", i, -1);
        end
        chk(1, "R9", "delivery sweep", 0, 0);
        summary();
    end
endmodule